// File: doc/BRIEF.md
# Serial-Addressed Successive-Approximation Converter Control Core

This block is the digital sequencer of an 8-bit successive-approximation converter. A host talks to it over a three-wire serial link: an active-low select, a serial clock and a data-in line, with results returned on a data-out line that has its own output enable. The ladder, the analog multiplexer and the comparator sit outside the block. The core presents a trial code to the ladder and reads back one comparator bit per clock. It also drives the channel and mode selection for the multiplexer.

A transaction opens when select falls. The host shifts in a start bit and then a short assignment word that picks the channel and the input mode. The core inserts one settling period and then decides the result one bit per clock, MSB first. Each bit appears on the data-out line as soon as it is decided. The result is then replayed LSB first. A hold input can keep the LSB level on the line and delay that replay. Raising select ends the transaction at any point and clears the core.

Top module: `sarlink_core`

## Requirements
- R1: While `cs_n` is high, every register is held clear: `dout_oe`, `dout` and `busy` are low, `trial_code` is zero, and `chan_sel`/`diff_mode` are zero.
- R2: `din` is sampled on rising `sclk` edges only. Low bits before the first high bit are ignored, and the first high bit is taken as the start bit.
- R3: The bits after the start bit are, in order: single-ended flag, sign, select-1, select-0 (three bits when FOUR_CH=1, with select-0 taken as 1). On the edge that samples the last of them, `chan_sel` becomes {select-1, select-0, sign} ({0, select-1, sign} when FOUR_CH=1) and `diff_mode` becomes the inverse of the single-ended flag. Both then hold until `cs_n` rises.
- R4: `busy` rises on the edge that samples the last assignment bit. From then on `din` has no effect on any output for the rest of the transaction.
- R5: At the first falling edge after `busy` rises, `dout_oe` goes high and `dout` drives 0 for one settling period.
- R6: In the trial period for bit i (from bit 7 down to bit 0), `trial_code` holds the bits already decided above i, has bit i set and has all lower bits clear. Bit i is kept when `cmp_ge` is 1 and cleared otherwise. Outside trial periods `trial_code` is zero.
- R7: Each decided bit is driven on `dout` at the falling edge inside its own trial period, MSB first. `busy` falls on the rising edge that ends the bit-0 period, so it is high for exactly 9 periods.
- R8: After the MSB-first stream, bits 1 to 7 follow on `dout` at successive falling edges. While `lsb_hold` is high at a falling edge before that replay has begun, `dout` keeps bit 0. Once the replay has begun it runs to the end.
- R9: After bit 7 of the replay, `dout` stays 0 and `dout_oe` stays high until `cs_n` rises.
- R10: A rising `cs_n`, including one during a conversion, clears the core at once. The next conversion needs a new falling `cs_n` and a new start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; rising edge samples `din`, falling edge updates `dout` |
| cs_n | input | 1 | Active-low select; high clears the core asynchronously |
| din | input | 1 | Serial start bit and assignment word |
| cmp_ge | input | 1 | Comparator result: input at or above ladder level |
| lsb_hold | input | 1 | High keeps the LSB on `dout` and delays the LSB-first replay |
| trial_code | output | DATA_W | Code presented to the ladder |
| chan_sel | output | 3 | Latched channel selection |
| diff_mode | output | 1 | Latched differential-mode flag |
| busy | output | 1 | Conversion in progress |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for `dout` |

## Verification
The assertions assume that `cs_n` changes only when it is not near a rising `sclk` edge, so the clear never races a sample. They also assume that `cmp_ge` is settled at each falling edge. The stimulus moves `cs_n`, `din` and `lsb_hold` a short time after each falling edge. The bench's comparator is a pure combinational compare against the present `trial_code`, so its output is stable well before the next falling edge. Random `din` during conversion and a mid-conversion deselect exercise the ignore and clear rules without breaking those timing assumptions.

// File: rtl/sarlink_pkg.sv
package sarlink_pkg;

   // sequencing phases of one transaction
   typedef enum logic [1:0] {
      PH_SEEK   = 2'd0,
      PH_SETTLE = 2'd1,
      PH_TRIAL  = 2'd2,
      PH_TAIL   = 2'd3
   } phase_t;

   localparam int unsigned CH_SEL_W = 3;

endpackage

// File: rtl/sarlink_addr.sv
module sarlink_addr
   import sarlink_pkg::*;
#(
   parameter int unsigned FOUR_CH = 0
)(
   input  logic                clk,
   input  logic                clr,
   input  logic                seek,
   input  logic                din,
   output logic                hit,
   output logic [CH_SEL_W-1:0] chan_sel,
   output logic                diff_mode
);

   localparam int unsigned ADDR_BITS = (FOUR_CH != 0) ? 3 : 4;
   localparam int unsigned SR_W      = ADDR_BITS + 1;

   logic [SR_W-1:0]     sr_q;
   logic [SR_W-1:0]     sr_nxt;
   logic [CH_SEL_W-1:0] chan_nxt;
   logic                dif_nxt;

   // start bit walks up; when it reaches the top the word is complete
   assign sr_nxt = {sr_q[SR_W-2:0], din};
   assign hit    = seek & sr_nxt[SR_W-1];

   generate
      if (FOUR_CH != 0) begin : g_four
         // order: single, sign, sel1 ; sel0 implied high
         assign chan_nxt = {1'b0, sr_nxt[0], sr_nxt[1]};
         assign dif_nxt  = ~sr_nxt[2];
      end else begin : g_eight
         // order: single, sign, sel1, sel0
         assign chan_nxt = {sr_nxt[1], sr_nxt[0], sr_nxt[2]};
         assign dif_nxt  = ~sr_nxt[3];
      end
   endgenerate

   always_ff @(posedge clk or posedge clr) begin
      if (clr) begin
         sr_q      <= '0;
         chan_sel  <= '0;
         diff_mode <= 1'b0;
      end else if (seek) begin
         sr_q <= sr_nxt;
         if (hit) begin
            chan_sel  <= chan_nxt;
            diff_mode <= dif_nxt;
         end
      end
   end

endmodule

// File: rtl/sarlink_seq.sv
module sarlink_seq
   import sarlink_pkg::*;
#(
   parameter int unsigned DATA_W = 8
)(
   input  logic              clk,
   input  logic              clr,
   input  logic              go,
   input  logic              dbit,
   output phase_t            phase,
   output logic              busy,
   output logic [DATA_W-1:0] result,
   output logic [DATA_W-1:0] trial_code
);

   localparam int unsigned     IDX_W   = $clog2(DATA_W);
   localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(DATA_W - 1);

   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] probe;

   assign probe      = {{(DATA_W-1){1'b0}}, 1'b1} << idx_q;
   assign trial_code = (phase == PH_TRIAL) ? (result | probe) : '0;

   always_ff @(posedge clk or posedge clr) begin
      if (clr) begin
         phase  <= PH_SEEK;
         busy   <= 1'b0;
         idx_q  <= '0;
         result <= '0;
      end else begin
         case (phase)
            PH_SEEK: begin
               if (go) begin
                  phase <= PH_SETTLE;
                  busy  <= 1'b1;
               end
            end
            PH_SETTLE: begin
               phase <= PH_TRIAL;
               idx_q <= IDX_TOP;
            end
            PH_TRIAL: begin
               result[idx_q] <= dbit;
               if (idx_q == '0) begin
                  phase <= PH_TAIL;
                  busy  <= 1'b0;
               end else begin
                  idx_q <= idx_q - 1'b1;
               end
            end
            default: begin
               phase <= phase;
            end
         endcase
      end
   end

endmodule

// File: rtl/sarlink_txout.sv
module sarlink_txout
   import sarlink_pkg::*;
#(
   parameter int unsigned DATA_W = 8
)(
   input  logic              clk,
   input  logic              clr,
   input  phase_t            phase,
   input  logic              cmp_ge,
   input  logic              lsb_hold,
   input  logic [DATA_W-1:0] result,
   output logic              dout,
   output logic              dout_oe,
   output logic              dbit
);

   localparam int unsigned      PTR_W   = $clog2(DATA_W + 1);
   localparam int unsigned      IDX_W   = $clog2(DATA_W);
   localparam logic [PTR_W-1:0] PTR_END = PTR_W'(DATA_W);
   localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

   logic [PTR_W-1:0] ptr_q;
   logic             replay_q;

   // launches on the falling edge so a rising-edge host sees settled data
   always_ff @(negedge clk or posedge clr) begin
      if (clr) begin
         dout     <= 1'b0;
         dout_oe  <= 1'b0;
         dbit     <= 1'b0;
         ptr_q    <= PTR_ONE;
         replay_q <= 1'b0;
      end else begin
         case (phase)
            PH_SETTLE: begin
               dout_oe <= 1'b1;
               dout    <= 1'b0;
            end
            PH_TRIAL: begin
               dout <= cmp_ge;
               dbit <= cmp_ge;
            end
            PH_TAIL: begin
               if (replay_q || !lsb_hold) begin
                  replay_q <= 1'b1;
                  if (ptr_q != PTR_END) begin
                     dout  <= result[ptr_q[IDX_W-1:0]];
                     ptr_q <= ptr_q + 1'b1;
                  end else begin
                     dout <= 1'b0;
                  end
               end
            end
            default: begin
               dout <= dout;
            end
         endcase
      end
   end

endmodule

// File: rtl/sarlink_core.sv
module sarlink_core
   import sarlink_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned FOUR_CH = 0
)(
   input  logic                sclk,
   input  logic                cs_n,
   input  logic                din,
   input  logic                cmp_ge,
   input  logic                lsb_hold,
   output logic [DATA_W-1:0]   trial_code,
   output logic [CH_SEL_W-1:0] chan_sel,
   output logic                diff_mode,
   output logic                busy,
   output logic                dout,
   output logic                dout_oe
);

   generate
      if (DATA_W < 2 || DATA_W > 16) begin : g_bad_width
         $error("sarlink_core: DATA_W must lie in 2..16");
      end
      if (FOUR_CH > 1) begin : g_bad_variant
         $error("sarlink_core: FOUR_CH must be 0 or 1");
      end
   endgenerate

   phase_t            phase;
   logic              hit;
   logic              dbit;
   logic [DATA_W-1:0] result;

   sarlink_addr #(.FOUR_CH(FOUR_CH)) u_addr (
      .clk       (sclk),
      .clr       (cs_n),
      .seek      (phase == PH_SEEK),
      .din       (din),
      .hit       (hit),
      .chan_sel  (chan_sel),
      .diff_mode (diff_mode)
   );

   sarlink_seq #(.DATA_W(DATA_W)) u_seq (
      .clk        (sclk),
      .clr        (cs_n),
      .go         (hit),
      .dbit       (dbit),
      .phase      (phase),
      .busy       (busy),
      .result     (result),
      .trial_code (trial_code)
   );

   sarlink_txout #(.DATA_W(DATA_W)) u_tx (
      .clk      (sclk),
      .clr      (cs_n),
      .phase    (phase),
      .cmp_ge   (cmp_ge),
      .lsb_hold (lsb_hold),
      .result   (result),
      .dout     (dout),
      .dout_oe  (dout_oe),
      .dbit     (dbit)
   );

endmodule

// File: rtl/sarlink_chk.sv
module sarlink_chk #(
   parameter int unsigned DATA_W = 8
)(
   input logic              sclk,
   input logic              cs_n,
   input logic              busy,
   input logic              dout_oe,
   input logic              diff_mode,
   input logic [2:0]        chan_sel,
   input logic [DATA_W-1:0] trial_code
);

   localparam int unsigned CNT_W = $clog2(DATA_W + 2) + 1;

   logic [CNT_W-1:0] busy_cnt;

   always_ff @(posedge sclk or posedge cs_n) begin
      if (cs_n)      busy_cnt <= '0;
      else if (busy) busy_cnt <= busy_cnt + 1'b1;
   end

   // R1: deselected core is quiet
   a_r1_quiet_when_deselected: assert property (@(posedge sclk)
      cs_n |-> (!busy && !dout_oe && trial_code == '0));

   // R3 / R4: selection frozen once conversion runs
   a_r3_selection_frozen: assert property (@(posedge sclk) disable iff (cs_n)
      (busy && $past(busy)) |-> ($stable(chan_sel) && $stable(diff_mode)));

   // R5: enable raised after the settling edge
   a_r5_enable_in_conversion: assert property (@(posedge sclk) disable iff (cs_n)
      (busy && $past(busy)) |-> dout_oe);

   // R6: ladder code only during conversion
   a_r6_trial_only_busy: assert property (@(posedge sclk) disable iff (cs_n)
      (trial_code != '0) |-> busy);

   // R7: busy lasts settling slot plus one period per bit
   a_r7_busy_window: assert property (@(posedge sclk) disable iff (cs_n)
      busy |-> (busy_cnt <= CNT_W'(DATA_W)));

   // R9: enable is never dropped while selected
   a_r9_enable_held: assert property (@(posedge sclk) disable iff (cs_n)
      $past(dout_oe) |-> dout_oe);

   // R10: one conversion per select window
   a_r10_single_conversion: assert property (@(posedge sclk) disable iff (cs_n)
      $rose(busy) |-> (busy_cnt == '0));

endmodule

bind sarlink_core sarlink_chk #(.DATA_W(DATA_W)) u_chk (
   .sclk       (sclk),
   .cs_n       (cs_n),
   .busy       (busy),
   .dout_oe    (dout_oe),
   .diff_mode  (diff_mode),
   .chan_sel   (chan_sel),
   .trial_code (trial_code)
);

// File: tb/sim_sarlink_core.sv
module sim_sarlink_core;

   localparam int CLK_P = 10;

   typedef struct {
      logic       dv;
      logic       oe;
      logic       bz;
      logic       chk_ch;
      logic [2:0] ch;
      logic       dif;
      logic [7:0] tr;
      int         req;
   } exp_t;

   logic       sclk = 1'b0;
   logic       cs_n = 1'b0;
   logic       din = 1'b0;
   logic       lsb_hold = 1'b0;
   logic [7:0] ain_q = 8'h00;
   logic       cmp_ge;
   logic [7:0] trial_code;
   logic [2:0] chan_sel;
   logic       diff_mode, busy, dout, dout_oe;

   int   n_vec = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;
   exp_t exq[$];

   always #(CLK_P/2) sclk = ~sclk;

   // comparator model: analog input at or above ladder level
   assign cmp_ge = (trial_code <= ain_q);

   sarlink_core u0 (
      .sclk       (sclk),
      .cs_n       (cs_n),
      .din        (din),
      .cmp_ge     (cmp_ge),
      .lsb_hold   (lsb_hold),
      .trial_code (trial_code),
      .chan_sel   (chan_sel),
      .diff_mode  (diff_mode),
      .busy       (busy),
      .dout       (dout),
      .dout_oe    (dout_oe)
   );

   // monitor: pop one expectation per period, sampled after the falling edge
   initial begin
      forever begin
         exp_t e;
         bit   bad;
         @(negedge sclk);
         #3;
         if (exq.size() > 0) begin
            e   = exq.pop_front();
            bad = 1'b0;
            n_vec++;
            if (dout !== e.dv) begin
               bad = 1'b1;
               $display("FAIL R%0d dout actual=%b expected=%b", e.req, dout, e.dv);
            end
            if (dout_oe !== e.oe) begin
               bad = 1'b1;
               $display("FAIL R5 dout_oe actual=%b expected=%b (item R%0d)", dout_oe, e.oe, e.req);
            end
            if (busy !== e.bz) begin
               bad = 1'b1;
               $display("FAIL R4 busy actual=%b expected=%b (item R%0d)", busy, e.bz, e.req);
            end
            if (trial_code !== e.tr) begin
               bad = 1'b1;
               $display("FAIL R6 trial_code actual=%h expected=%h", trial_code, e.tr);
            end
            if (e.chk_ch && (chan_sel !== e.ch || diff_mode !== e.dif)) begin
               bad = 1'b1;
               $display("FAIL R3 chan/diff actual=%0d/%b expected=%0d/%b",
                        chan_sel, diff_mode, e.ch, e.dif);
            end
            if (bad) n_bad++;
         end
      end
   end

   function automatic exp_t quiet(input int req);
      exp_t e;
      e.dv = 1'b0; e.oe = 1'b0; e.bz = 1'b0; e.chk_ch = 1'b1;
      e.ch = 3'd0; e.dif = 1'b0; e.tr = 8'h00; e.req = req;
      return e;
   endfunction

   task automatic step(input logic cs_v, input logic din_v, input logic hold_v, input exp_t e);
      @(negedge sclk);
      #1;
      cs_n     = cs_v;
      din      = din_v;
      lsb_hold = hold_v;
      exq.push_back(e);
   endtask

   // driver: one transaction; expectations derived from the requirements
   task automatic run_txn(input int lead, input bit sgl, input bit sgn, input bit s1,
                          input bit s0, input logic [7:0] ain_v, input int hold_n,
                          input bit junk, input int abort_at);
      int settle = lead + 5;
      int t0     = lead + 14;
      int last   = t0 + hold_n + 9;
      ain_q = ain_v;
      for (int p = 0; p <= last; p++) begin
         exp_t e;
         logic dv;
         logic hv;
         e  = quiet(2);
         e.chk_ch = 1'b0;
         if (p < lead)          dv = 1'b0;                 // R2 leading lows ignored
         else if (p == lead)    dv = 1'b1;                 // start bit
         else if (p == lead+1)  dv = sgl;
         else if (p == lead+2)  dv = sgn;
         else if (p == lead+3)  dv = s1;
         else if (p == lead+4)  dv = s0;
         else                   dv = junk ? logic'($urandom_range(1, 0)) : 1'b0; // R4
         hv = ((p + 1 - t0) < hold_n);
         if (p >= settle) begin
            e.chk_ch = 1'b1;
            e.ch     = {s1, s0, sgn};                      // R3 mapping
            e.dif    = ~sgl;
            e.oe     = 1'b1;
         end
         if (p == settle) begin
            e.bz  = 1'b1;                                  // R5 settling low
            e.dv  = 1'b0;
            e.req = 5;
         end else if (p > settle && p < t0) begin
            int i = 7 - (p - settle - 1);
            int tv;
            tv    = (int'(ain_v) & ~((1 << (i + 1)) - 1)) | (1 << i);
            e.bz  = 1'b1;
            e.dv  = ain_v[i];                              // R7 MSB first
            e.tr  = tv[7:0];                               // R6 trial code
            e.req = 7;
         end else if (p >= t0) begin
            int m = p - t0;
            if (m < hold_n) begin
               e.dv  = ain_v[0];                           // R8 held LSB
               e.req = 8;
            end else if (m - hold_n < 7) begin
               e.dv  = ain_v[1 + m - hold_n];              // R8 LSB-first replay
               e.req = 8;
            end else begin
               e.dv  = 1'b0;                               // R9 trailing low
               e.req = 9;
            end
         end
         if (abort_at > 0 && p == abort_at) begin
            step(1'b1, 1'b0, 1'b0, quiet(10));             // R10 mid-run deselect
            return;
         end
         step(1'b0, dv, hv, e);
      end
      step(1'b1, 1'b0, 1'b0, quiet(10));                   // R10 / R1 clear on deselect
      step(1'b1, 1'b1, 1'b0, quiet(1));
   endtask

   initial begin
      #1 cs_n = 1'b1;
      // R1: reset state while deselected, din toggling
      step(1'b1, 1'b1, 1'b0, quiet(1));
      step(1'b1, 1'b0, 1'b1, quiet(1));
      step(1'b1, 1'b1, 1'b0, quiet(1));
      run_txn(2, 1'b1, 1'b1, 1'b0, 1'b1, 8'hA5, 0, 1'b0, 0);
      run_txn(0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 3, 1'b0, 0);
      run_txn(5, 1'b1, 1'b0, 1'b1, 1'b0, 8'hFF, 0, 1'b1, 0);
      run_txn(1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h80, 6, 1'b1, 0);
      run_txn(3, 1'b1, 1'b1, 1'b1, 1'b1, 8'h3C, 0, 1'b0, 9);
      run_txn(0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h01, 1, 1'b0, 0);
      run_txn(1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h7F, 2, 1'b1, 0);
      run_txn(0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h5A, 0, 1'b1, 0);
      repeat (3) @(negedge sclk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge sclk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog (R1..all) actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule